// File: doc/BRIEF.md
# 64-bit Memory Window Base Register Block

This block holds the configuration registers that place one function's 4 KB memory window anywhere in a 64-bit address space. Software programs a pair of base dwords. The lower dword of the pair carries fixed, read-only type bits. The block then compares each incoming memory address against that base and raises a hit output for addresses inside the window. The window decodes only while the command register's memory-space enable is set and the 64-bit base is not all zero.

The block also holds a 16-bit subsystem vendor identifier that firmware writes once. The first write that touches the field stores the value and locks it. After that, reads still return the value, but writes no longer change it. The block has two reset inputs. The power-management reset clears the base pair only, and the identifier and its lock survive it. The full reset clears everything. The configuration port uses dword addresses and per-byte enables. Write data is captured on the clock edge, while read data and the hit output are combinational from the stored state.

Top module: `cfg_bar64_window`

## Requirements
- R1: After the full reset, the low base dword (byte offset 10h, dword 4) reads 0000_0004h, the high base dword (offset 14h, dword 5) reads 0, and the identifier dword (offset 2Ch, dword 0Bh) reads 0.
- R2: In the low base dword, only bits 31:12 can be written. Bits 11:4 always read 0, bit 3 reads 0, bits 2:1 read 10b and bit 0 reads 0, whatever is written.
- R3: All 32 bits of the high base dword can be written and read back.
- R4: On a write, byte lane n (bits 8n+7:8n) changes only when cfg_be[n] is 1.
- R5: Reads of any other dword offset return 0. Writes to such offsets leave the implemented registers unchanged.
- R6: mem_hit is 1 when mem_addr[63:12] equals {high dword, low bits 31:12}, memory space is enabled and the window is active. Otherwise it is 0.
- R7: mem_hit is 0 whenever mem_space_en is 0.
- R8: The window is active only when at least one of the two base halves is non-zero. A non-zero value in either half alone is enough.
- R9: The identifier (bits 15:0 of dword 0Bh) stores its first write under the byte enables. Every later write is ignored, and reads always return the stored value. Bits 31:16 read 0.
- R10: The lock is set by a write to dword 0Bh with cfg_be[0] or cfg_be[1] set. A write that enables only bytes 3:2 neither stores data nor locks.
- R11: A power-management reset pulse (pm_rst_n low) clears both base dwords to their reset values. It does not change the identifier or its lock.
- R12: The full reset clears the identifier and its lock, so the identifier can be written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full synchronous reset, active low |
| pm_rst_n | input | 1 | Power-management synchronous reset, active low; clears the base registers only |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 6 | Configuration dword address |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| mem_space_en | input | 1 | Memory space enable bit from the command register |
| mem_addr | input | 64 | Memory address to decode |
| mem_hit | output | 1 | Address falls inside the active window (combinational) |

## Verification
A write is captured on the rising edge where cfg_wr is high. Its effect is visible on cfg_rdata in the same cycle that follows, because the read path adds no register. The bench drives each write from one falling edge to the next. It then moves cfg_addr to the register of interest and samples 1 ns later, well before the next rising edge. mem_hit has no register on its path, so the bench samples it 1 ns after changing mem_addr or mem_space_en. A reset pulse is held for one full rising edge, and the registers are read back in the following low phase.

// File: rtl/bar64_pkg.sv
package bar64_pkg;
  // Dword indices of the implemented configuration registers
  localparam int unsigned BASE_LO_DW = 4;   // byte offset 10h
  localparam int unsigned BASE_HI_DW = 5;   // byte offset 14h
  localparam int unsigned SUBVID_DW  = 11;  // byte offset 2Ch

  // Read-only type bits of the low base dword: not prefetchable,
  // placeable anywhere in 64-bit space, memory space
  localparam logic [3:0] BASE_TYPE_BITS = 4'b0100;

  // Per-byte write merge
  function automatic logic [31:0] be_merge(input logic [31:0] cur,
                                           input logic [31:0] nw,
                                           input logic [3:0]  be);
    logic [31:0] r;
    r = cur;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/bar64_base_regs.sv
module bar64_base_regs
  import bar64_pkg::*;
#(
  parameter int AW       = 6,
  parameter int WIN_LOG2 = 12,
  localparam int TBA_W   = 32 - WIN_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pm_rst_n,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  output logic [TBA_W-1:0] lo_tba,
  output logic [31:0]      hi_base
);
  logic        lo_sel, hi_sel;
  logic [31:0] lo_merged, hi_merged;
  logic        unused_lo;

  assign lo_sel = wr && (addr == AW'(BASE_LO_DW));
  assign hi_sel = wr && (addr == AW'(BASE_HI_DW));

  always_comb begin
    lo_merged = be_merge({lo_tba, {WIN_LOG2{1'b0}}}, wdata, be);
    hi_merged = be_merge(hi_base, wdata, be);
  end

  assign unused_lo = ^lo_merged[WIN_LOG2-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || !pm_rst_n) begin
      lo_tba  <= '0;
      hi_base <= '0;
    end else begin
      if (lo_sel) lo_tba  <= lo_merged[31:WIN_LOG2];
      if (hi_sel) hi_base <= hi_merged;
    end
  end
endmodule

// File: rtl/subvid_once_reg.sv
module subvid_once_reg
  import bar64_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        sel,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  output logic [15:0] value,
  output logic        locked,
  output logic        lock_evt
);
  logic [31:0] merged;

  // First write that touches either identifier byte
  assign lock_evt = wr && sel && (|be) && !locked;

  always_comb merged = be_merge({16'h0, value}, {16'h0, wdata}, {2'b00, be});

  // Only the full reset reaches this register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value  <= '0;
      locked <= 1'b0;
    end else if (lock_evt) begin
      value  <= merged[15:0];
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/bar64_window_match.sv
module bar64_window_match #(
  parameter int WIN_LOG2 = 12,
  localparam int TBA_W   = 32 - WIN_LOG2,
  localparam int PAGE_W  = 64 - WIN_LOG2
) (
  input  logic              mse,
  input  logic [TBA_W-1:0]  lo_tba,
  input  logic [31:0]       hi_base,
  input  logic [PAGE_W-1:0] page,
  output logic              win_on,
  output logic              hit
);
  function automatic logic window_active(input logic en,
                                         input logic [PAGE_W-1:0] base);
    return en && (base != '0);
  endfunction

  logic [PAGE_W-1:0] base_page;
  assign base_page = {hi_base, lo_tba};
  assign win_on    = window_active(mse, base_page);
  assign hit       = win_on && (page == base_page);
endmodule

// File: rtl/cfg_bar64_window.sv
module cfg_bar64_window
  import bar64_pkg::*;
#(
  parameter int AW       = 6,
  parameter int WIN_LOG2 = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pm_rst_n,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_addr,
  input  logic [3:0]    cfg_be,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          mem_space_en,
  input  logic [63:0]   mem_addr,
  output logic          mem_hit
);
  localparam int TBA_W = 32 - WIN_LOG2;
  localparam int PAD_W = WIN_LOG2 - 4;

  logic [TBA_W-1:0] lo_tba;
  logic [31:0]      hi_base;
  logic [15:0]      subvid;
  logic             subvid_locked;
  logic             subvid_lock_evt;
  logic             win_on;
  logic             subvid_sel;
  logic             unused_addr;

  assign subvid_sel  = (cfg_addr == AW'(SUBVID_DW));
  assign unused_addr = ^mem_addr[WIN_LOG2-1:0];

  bar64_base_regs #(.AW(AW), .WIN_LOG2(WIN_LOG2)) base_i (
    .clk(clk), .rst_n(rst_n), .pm_rst_n(pm_rst_n),
    .wr(cfg_wr), .addr(cfg_addr), .be(cfg_be), .wdata(cfg_wdata),
    .lo_tba(lo_tba), .hi_base(hi_base)
  );

  subvid_once_reg subvid_i (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(subvid_sel),
    .be(cfg_be[1:0]), .wdata(cfg_wdata[15:0]),
    .value(subvid), .locked(subvid_locked), .lock_evt(subvid_lock_evt)
  );

  bar64_window_match #(.WIN_LOG2(WIN_LOG2)) match_i (
    .mse(mem_space_en), .lo_tba(lo_tba), .hi_base(hi_base),
    .page(mem_addr[63:WIN_LOG2]), .win_on(win_on), .hit(mem_hit)
  );

  always_comb begin
    case (cfg_addr)
      AW'(BASE_LO_DW): cfg_rdata = {lo_tba, {PAD_W{1'b0}}, BASE_TYPE_BITS};
      AW'(BASE_HI_DW): cfg_rdata = hi_base;
      AW'(SUBVID_DW):  cfg_rdata = {16'h0, subvid};
      default:         cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_bar64_window_chk.sv
module cfg_bar64_window_chk
  import bar64_pkg::*;
#(
  parameter int AW       = 6,
  parameter int WIN_LOG2 = 12,
  localparam int TBA_W   = 32 - WIN_LOG2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pm_rst_n,
  input logic             cfg_wr,
  input logic [AW-1:0]    cfg_addr,
  input logic [3:0]       cfg_be,
  input logic [31:0]      cfg_rdata,
  input logic             mem_space_en,
  input logic [63:0]      mem_addr,
  input logic             mem_hit,
  input logic [TBA_W-1:0] lo_tba,
  input logic [31:0]      hi_base,
  input logic [15:0]      subvid,
  input logic             subvid_locked,
  input logic             win_on
);
  logic other_dw;
  assign other_dw = (cfg_addr != AW'(BASE_LO_DW)) && (cfg_addr != AW'(BASE_HI_DW)) &&
                    (cfg_addr != AW'(SUBVID_DW));

  AST_LO_TYPE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == AW'(BASE_LO_DW)) |-> (cfg_rdata[WIN_LOG2-1:0] == WIN_LOG2'(BASE_TYPE_BITS))); // R2
  AST_OTHER_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    other_dw |-> (cfg_rdata == 32'h0)); // R5
  AST_HIT_PAGE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> (mem_addr[63:WIN_LOG2] == {hi_base, lo_tba})); // R6
  AST_HIT_NEEDS_MSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> mem_space_en); // R7
  AST_HIT_NEEDS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> (win_on && ({hi_base, lo_tba} != '0))); // R8
  AST_SUBVID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    subvid_locked |=> $stable(subvid)); // R9
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    subvid_locked |=> subvid_locked); // R9
  AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!subvid_locked && !(cfg_wr && cfg_addr == AW'(SUBVID_DW) && |cfg_be[1:0])) |=> !subvid_locked); // R10
  AST_PM_CLEARS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_rst_n |=> (lo_tba == '0 && hi_base == '0)); // R11
  AST_PM_KEEPS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (!pm_rst_n && !cfg_wr) |=> ($stable(subvid) && $stable(subvid_locked))); // R11
endmodule

bind cfg_bar64_window cfg_bar64_window_chk #(.AW(AW), .WIN_LOG2(WIN_LOG2)) chk_i (
  .clk(clk), .rst_n(rst_n), .pm_rst_n(pm_rst_n), .cfg_wr(cfg_wr),
  .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
  .mem_space_en(mem_space_en), .mem_addr(mem_addr), .mem_hit(mem_hit),
  .lo_tba(lo_tba), .hi_base(hi_base), .subvid(subvid),
  .subvid_locked(subvid_locked), .win_on(win_on)
);

// File: tb/cfg_bar64_window_tb_top.sv
module cfg_bar64_window_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pm_rst_n = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_space_en = 1'b0;
  logic [63:0] mem_addr = '0;
  logic        mem_hit;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  cfg_bar64_window dut_i (
    .clk(clk), .rst_n(rst_n), .pm_rst_n(pm_rst_n), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mem_space_en(mem_space_en),
    .mem_addr(mem_addr), .mem_hit(mem_hit)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  woff;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [7:0]  roff;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // Each vector: optional write, then read back one byte offset
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h10, 4'hF, 32'hFFFF_FFFF, 8'h10, 32'hFFFF_F004, 8'd2},  // R2
    '{1'b1, 8'h10, 4'h4, 32'h0000_0000, 8'h10, 32'hFF00_F004, 8'd4},  // R4
    '{1'b1, 8'h14, 4'hF, 32'h1234_5678, 8'h14, 32'h1234_5678, 8'd3},  // R3
    '{1'b1, 8'h14, 4'h8, 32'hAB00_0000, 8'h14, 32'hAB34_5678, 8'd4},  // R4
    '{1'b1, 8'h18, 4'hF, 32'hFFFF_FFFF, 8'h18, 32'h0000_0000, 8'd5},  // R5
    '{1'b0, 8'h00, 4'h0, 32'h0000_0000, 8'h10, 32'hFF00_F004, 8'd5},  // R5
    '{1'b1, 8'h2C, 4'hC, 32'hDEAD_0000, 8'h2C, 32'h0000_0000, 8'd10}, // R10
    '{1'b1, 8'h2C, 4'h3, 32'h1111_BEEF, 8'h2C, 32'h0000_BEEF, 8'd9},  // R9
    '{1'b1, 8'h2C, 4'h3, 32'h0000_1234, 8'h2C, 32'h0000_BEEF, 8'd9},  // R9
    '{1'b1, 8'h2C, 4'h1, 32'h0000_0055, 8'h2C, 32'h0000_BEEF, 8'd10}  // R10
  };

  function automatic logic exp_hit(input logic mse, input logic [63:0] a,
                                   input logic [31:0] hi, input logic [31:0] lo);
    logic [51:0] base;
    base = {hi, lo[31:12]};
    if (!mse || base == 52'd0) return 1'b0;
    return (a >> 12) == {12'd0, base};
  endfunction

  task automatic cfg_write(input logic [7:0] off, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = off[7:2]; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic check_rd(input logic [7:0] off, input logic [31:0] exp, input int req);
    cfg_addr = off[7:2];
    #1;
    n_tests++;
    if (cfg_rdata !== exp) begin
      n_fail++;
      $display("FAIL R%0d: read %02h got %08h expected %08h", req, off, cfg_rdata, exp);
    end
  endtask

  task automatic check_hit(input logic mse, input logic [63:0] a,
                           input logic [31:0] hi, input logic [31:0] lo, input int req);
    logic e;
    mem_space_en = mse; mem_addr = a;
    #1;
    e = exp_hit(mse, a, hi, lo);
    n_tests++;
    if (mem_hit !== e) begin
      n_fail++;
      $display("FAIL R%0d: hit for %016h mse %0b got %0b expected %0b", req, a, mse, mem_hit, e);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    check_rd(8'h10, 32'h0000_0004, 1);
    check_rd(8'h14, 32'h0000_0000, 1);
    check_rd(8'h2C, 32'h0000_0000, 1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) cfg_write(VECS[i].woff, VECS[i].be, VECS[i].wdata);
      else @(negedge clk);
      check_rd(VECS[i].roff, VECS[i].exp, int'(VECS[i].req));
    end

    // R6: window match with base AB34_5678 / FF00_F000
    check_hit(1'b1, 64'hAB34_5678_FF00_FABC, 32'hAB34_5678, 32'hFF00_F004, 6);
    check_hit(1'b1, 64'hAB34_5678_FF00_EABC, 32'hAB34_5678, 32'hFF00_F004, 6);
    check_hit(1'b1, 64'hAB34_5778_FF00_F000, 32'hAB34_5678, 32'hFF00_F004, 6);
    // R7: memory space disabled
    check_hit(1'b0, 64'hAB34_5678_FF00_F123, 32'hAB34_5678, 32'hFF00_F004, 7);

    // R11: power-management reset clears bases, keeps identifier and lock
    @(negedge clk); pm_rst_n = 1'b0;
    @(negedge clk); pm_rst_n = 1'b1;
    check_rd(8'h10, 32'h0000_0004, 11);
    check_rd(8'h14, 32'h0000_0000, 11);
    check_rd(8'h2C, 32'h0000_BEEF, 11);
    cfg_write(8'h2C, 4'h3, 32'h0000_2222);
    check_rd(8'h2C, 32'h0000_BEEF, 11);

    // R8: zero base never decodes, even page zero
    check_hit(1'b1, 64'h0000_0000_0000_0010, 32'h0, 32'h4, 8);
    cfg_write(8'h14, 4'hF, 32'h0000_0001);
    check_hit(1'b1, 64'h0000_0001_0000_0FFF, 32'h1, 32'h4, 8);
    check_hit(1'b1, 64'h0000_0000_0000_0000, 32'h1, 32'h4, 8);
    cfg_write(8'h14, 4'hF, 32'h0000_0000);
    cfg_write(8'h10, 4'h2, 32'h0000_3000);
    check_hit(1'b1, 64'h0000_0000_0000_3ABC, 32'h0, 32'h0000_3004, 8);

    // R12: full reset clears identifier and lock
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_rd(8'h2C, 32'h0000_0000, 12);
    check_rd(8'h10, 32'h0000_0004, 1);
    cfg_write(8'h2C, 4'h3, 32'h0000_7777);
    check_rd(8'h2C, 32'h0000_7777, 12);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule